// File: doc/BRIEF.md
# Dual Wiper and Preset Register Bank

This block is the storage and command engine of a two-channel digital potentiometer. It sits behind a serial front end that has already framed each command. Each channel has a volatile 8-bit wiper position and four 8-bit preset slots that model nonvolatile storage. Each wiper drives a one-hot tap-select bus with one line per resistor tap.

Commands arrive as one-cycle pulses carrying an opcode, a channel, a preset index and a data byte. The block accepts or rejects each command. It reports read data one cycle later. Any change to a preset opens a busy window, whose length is a parameter counted in clocks. During that window every command is refused. A low write-enable pin blocks preset changes. When reset is released, the block spends one cycle loading each wiper from its preset 0, so the presets carry their contents across a reset.

Top module: `dpot_regbank`

## Requirements
- R1: While `rst_n` is low, `cmd_accept`, `cmd_reject` and `rd_valid` are low, `busy` is high and both wipers read 0. In the first clock after release, `busy` stays high while each wiper loads its preset 0. From the next cycle `busy` is low.
- R2: Opcode 1 (write wiper) sets the wiper of channel `cmd_pot` (0 or 1) to `cmd_data`, one cycle after the command. The other wiper is unchanged.
- R3: Opcode 0 (read wiper) and opcode 2 (read preset `cmd_sel` of channel `cmd_pot`) pulse `rd_valid` one cycle after the command, with the stored value on `rd_data`.
- R4: Opcode 3 (write preset `cmd_sel` of channel `cmd_pot` with `cmd_data`), and the store opcodes 5 and 7, keep `busy` high for exactly `BUSY_CYCLES` cycles starting the cycle after the command.
- R5: A command that arrives while `busy` is high is rejected and changes no wiper or preset.
- R6: With `wp_n` low, opcodes 3, 5 and 7 are accepted but change no preset and do not raise `busy`. Reads still work.
- R7: Opcode 4 loads the wiper of channel `cmd_pot` from its preset `cmd_sel`. Opcode 5 stores that wiper into its preset `cmd_sel`.
- R8: Opcode 6 loads both wipers from their own preset `cmd_sel`. Opcode 7 stores both wipers into their own preset `cmd_sel`.
- R9: Opcode 8 moves the wiper of channel `cmd_pot` by one position. It moves up when `cmd_data[0]` is 1 and down when it is 0. The wiper saturates at FFh and at 00h.
- R10: Each tap bus has exactly one bit set, at the index equal to its wiper value. Bit 0 is the low terminal and bit 255 is the high terminal.
- R11: Opcodes 9 to 15 are rejected and change nothing.
- R12: Every command cycle is followed one cycle later by exactly one of `cmd_accept` or `cmd_reject`. A cycle with no command is followed by neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts the preset-0 recall |
| wp_n | input | 1 | Low blocks all preset changes |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 4 | Opcode 0 to 8 |
| cmd_pot | input | 1 | Channel select |
| cmd_sel | input | 2 | Preset index 0 to 3 |
| cmd_data | input | 8 | Write data; bit 0 gives the step direction |
| cmd_accept | output | 1 | Command was executed |
| cmd_reject | output | 1 | Command was refused |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read result, held until the next read |
| busy | output | 1 | Recall or nonvolatile write in progress |
| wiper0 | output | 8 | Channel 0 wiper position |
| wiper1 | output | 8 | Channel 1 wiper position |
| tap0 | output | 256 | Channel 0 one-hot tap select |
| tap1 | output | 256 | Channel 1 one-hot tap select |

## Verification
The checker enforces the following on every clock:
- the one-hot tap buses agree with the wipers;
- each command gets exactly one response;
- a command is refused while busy;
- a busy window never outlasts its limit;
- a protected preset write never raises busy;
- a direct wiper write lands the next cycle;
- an upward step at FFh stays at FFh.

Preset contents, the transfers between presets and wipers, the exact busy length and the recall after reset are only visible through the bench's scenarios. The bench writes values, moves them and reads them back.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_RD_WIPER  = 4'd0,
    OP_WR_WIPER  = 4'd1,
    OP_RD_PRESET = 4'd2,
    OP_WR_PRESET = 4'd3,
    OP_LOAD      = 4'd4,
    OP_STORE     = 4'd5,
    OP_GLOAD     = 4'd6,
    OP_GSTORE    = 4'd7,
    OP_STEP      = 4'd8
  } dpot_op_e;

  localparam logic [OP_W-1:0] OP_LAST = 4'd8;
endpackage

// File: rtl/dpot_busy_timer.sv
module dpot_busy_timer #(
  parameter int CYCLES = 625000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    if (start)            cnt_nxt = CNT_W'(CYCLES);
    else if (cnt_q != '0) cnt_nxt = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/dpot_tap_decode.sv
module dpot_tap_decode #(
  parameter int W = 8
) (
  input  logic [W-1:0]      pos,
  output logic [(1<<W)-1:0] tap
);
  localparam int NTAP = 1 << W;

  for (genvar i = 0; i < NTAP; i++) begin : g_line
    assign tap[i] = (pos == W'(i));
  end
endmodule

// File: rtl/dpot_channel.sv
module dpot_channel #(
  parameter int W       = 8,
  parameter int NPRESET = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       recall,
  input  logic                       ld_data_en,
  input  logic [W-1:0]               ld_data,
  input  logic                       ld_preset_en,
  input  logic                       st_data_en,
  input  logic                       st_wiper_en,
  input  logic                       step_en,
  input  logic                       step_up,
  input  logic [$clog2(NPRESET)-1:0] sel,
  output logic [W-1:0]               wiper_q,
  output logic [W-1:0]               preset_q
);
  localparam int SEL_W = $clog2(NPRESET);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [NPRESET-1:0][W-1:0] preset_all;
  logic [W-1:0]              wiper_nxt;
  logic [W-1:0]              st_val;

  assign st_val   = st_wiper_en ? wiper_q : ld_data;
  assign preset_q = preset_all[sel];

  // Preset slots model nonvolatile cells: no reset, written only on enable.
  for (genvar g = 0; g < NPRESET; g++) begin : g_slot
    logic         we;
    logic [W-1:0] cell_q;

    assign we = (st_data_en || st_wiper_en) && (sel == SEL_W'(g));

    always_ff @(posedge clk) begin
      if (we) cell_q <= st_val;
    end

    assign preset_all[g] = cell_q;
  end

  always_comb begin
    wiper_nxt = wiper_q;
    if (recall)            wiper_nxt = preset_all[0];
    else if (ld_data_en)   wiper_nxt = ld_data;
    else if (ld_preset_en) wiper_nxt = preset_all[sel];
    else if (step_en) begin
      if (step_up && wiper_q != TOP)       wiper_nxt = wiper_q + 1'b1;
      else if (!step_up && wiper_q != '0)  wiper_nxt = wiper_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wiper_q <= '0;
    else        wiper_q <= wiper_nxt;
  end
endmodule

// File: rtl/dpot_regbank.sv
module dpot_regbank
  import dpot_pkg::*;
#(
  parameter int W           = 8,
  parameter int NPRESET     = 4,
  parameter int BUSY_CYCLES = 625000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wp_n,
  input  logic                       cmd_valid,
  input  logic [OP_W-1:0]            cmd_op,
  input  logic                       cmd_pot,
  input  logic [$clog2(NPRESET)-1:0] cmd_sel,
  input  logic [W-1:0]               cmd_data,
  output logic                       cmd_accept,
  output logic                       cmd_reject,
  output logic                       rd_valid,
  output logic [W-1:0]               rd_data,
  output logic                       busy,
  output logic [W-1:0]               wiper0,
  output logic [W-1:0]               wiper1,
  output logic [(1<<W)-1:0]          tap0,
  output logic [(1<<W)-1:0]          tap1
);
  localparam int NCH  = 2;
  localparam int NTAP = 1 << W;

  dpot_op_e             op;
  logic                 recall_q;
  logic                 timer_busy;
  logic                 accept, is_nv, nv_go, rd_go;
  logic [W-1:0]         rd_val, rd_data_nxt;
  logic [NCH-1:0][W-1:0] wiper_a, preset_a;
  logic [NCH-1:0][NTAP-1:0] tap_a;

  assign op    = dpot_op_e'(cmd_op);
  assign busy  = recall_q | timer_busy;

  always_comb begin
    accept = cmd_valid && !busy && (cmd_op <= OP_LAST);
    is_nv  = (op == OP_WR_PRESET) || (op == OP_STORE) || (op == OP_GSTORE);
    nv_go  = accept && is_nv && wp_n;
    rd_go  = accept && ((op == OP_RD_WIPER) || (op == OP_RD_PRESET));
    rd_val = (op == OP_RD_WIPER) ? wiper_a[cmd_pot] : preset_a[cmd_pot];
    rd_data_nxt = rd_go ? rd_val : rd_data;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    logic ld_data_en, ld_preset_en, st_data_en, st_wiper_en, step_en;

    always_comb begin
      hit          = (cmd_pot == 1'(c));
      ld_data_en   = accept && hit && (op == OP_WR_WIPER);
      ld_preset_en = accept && (((op == OP_LOAD) && hit) || (op == OP_GLOAD));
      st_data_en   = nv_go && hit && (op == OP_WR_PRESET);
      st_wiper_en  = nv_go && (((op == OP_STORE) && hit) || (op == OP_GSTORE));
      step_en      = accept && hit && (op == OP_STEP);
    end

    dpot_channel #(.W(W), .NPRESET(NPRESET)) chan_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .recall       (recall_q),
      .ld_data_en   (ld_data_en),
      .ld_data      (cmd_data),
      .ld_preset_en (ld_preset_en),
      .st_data_en   (st_data_en),
      .st_wiper_en  (st_wiper_en),
      .step_en      (step_en),
      .step_up      (cmd_data[0]),
      .sel          (cmd_sel),
      .wiper_q      (wiper_a[c]),
      .preset_q     (preset_a[c])
    );

    dpot_tap_decode #(.W(W)) dec_i (
      .pos (wiper_a[c]),
      .tap (tap_a[c])
    );
  end

  dpot_busy_timer #(.CYCLES(BUSY_CYCLES)) timer_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (nv_go),
    .busy  (timer_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      recall_q   <= 1'b1;
      cmd_accept <= 1'b0;
      cmd_reject <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
    end else begin
      recall_q   <= 1'b0;
      cmd_accept <= accept;
      cmd_reject <= cmd_valid && !accept;
      rd_valid   <= rd_go;
      rd_data    <= rd_data_nxt;
    end
  end

  assign wiper0 = wiper_a[0];
  assign wiper1 = wiper_a[1];
  assign tap0   = tap_a[0];
  assign tap1   = tap_a[1];
endmodule

// File: rtl/dpot_regbank_chk.sv
module dpot_regbank_chk #(
  parameter int W           = 8,
  parameter int BUSY_CYCLES = 625000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wp_n,
  input logic              cmd_valid,
  input logic [3:0]        cmd_op,
  input logic              cmd_pot,
  input logic [W-1:0]      cmd_data,
  input logic              cmd_accept,
  input logic              cmd_reject,
  input logic              busy,
  input logic [W-1:0]      wiper0,
  input logic [W-1:0]      wiper1,
  input logic [(1<<W)-1:0] tap0,
  input logic [(1<<W)-1:0] tap1
);
  localparam int RW = $clog2(BUSY_CYCLES + 2) + 1;

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     run_q <= '0;
    else if (!busy)                 run_q <= '0;
    else if (run_q != {RW{1'b1}})   run_q <= run_q + 1'b1;
  end

  // R4
  always @(posedge clk) begin
    if (rst_n) begin
      busy_window_chk: assert (run_q <= RW'(BUSY_CYCLES));
    end
  end

  // R12
  one_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (cmd_accept != cmd_reject));

  // R12
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (!cmd_accept && !cmd_reject));

  // R10
  tap0_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(tap0) && tap0[wiper0]);

  // R10
  tap1_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(tap1) && tap1[wiper1]);

  // R5
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy) |=> cmd_reject);

  // R6
  wp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && !wp_n && cmd_op == 4'd3) |=> !busy);

  // R2
  wiper_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 4'd1 && !cmd_pot) |=> (wiper0 == $past(cmd_data)));

  // R9
  step_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 4'd8 && !cmd_pot && cmd_data[0] && wiper0 == {W{1'b1}})
    |=> (wiper0 == {W{1'b1}}));
endmodule

bind dpot_regbank dpot_regbank_chk #(.W(W), .BUSY_CYCLES(BUSY_CYCLES)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .wp_n       (wp_n),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .cmd_pot    (cmd_pot),
  .cmd_data   (cmd_data),
  .cmd_accept (cmd_accept),
  .cmd_reject (cmd_reject),
  .busy       (busy),
  .wiper0     (wiper0),
  .wiper1     (wiper1),
  .tap0       (tap0),
  .tap1       (tap1)
);

// File: tb/dpot_regbank_tb_top.sv
`timescale 1ns/1ps
module dpot_regbank_tb_top;
  localparam int BUSY = 12;

  logic         clk = 1'b0;
  logic         rst_n, wp_n, cmd_valid, cmd_pot;
  logic [3:0]   cmd_op;
  logic [1:0]   cmd_sel;
  logic [7:0]   cmd_data;
  logic         cmd_accept, cmd_reject, rd_valid, busy;
  logic [7:0]   rd_data, wiper0, wiper1;
  logic [255:0] tap0, tap1;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dpot_regbank #(.BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_pot(cmd_pot), .cmd_sel(cmd_sel), .cmd_data(cmd_data),
    .cmd_accept(cmd_accept), .cmd_reject(cmd_reject), .rd_valid(rd_valid),
    .rd_data(rd_data), .busy(busy), .wiper0(wiper0), .wiper1(wiper1),
    .tap0(tap0), .tap1(tap1)
  );

  typedef struct packed {
    logic [3:0] op;  logic pot; logic [1:0] sel; logic [7:0] data; logic wp;
    logic acc; logic rdv; logic [7:0] rd; logic bsy;
    logic [7:0] w0; logic [7:0] w1; logic [3:0] req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{4'd0,1'b0,2'd0,8'h00,1'b1, 1'b1,1'b1,8'h3C,1'b0, 8'h3C,8'hA5,4'd3},  // R3
    '{4'd0,1'b1,2'd0,8'h00,1'b1, 1'b1,1'b1,8'hA5,1'b0, 8'h3C,8'hA5,4'd3},  // R3
    '{4'd3,1'b0,2'd2,8'h77,1'b1, 1'b1,1'b0,8'h00,1'b1, 8'h3C,8'hA5,4'd4},  // R4
    '{4'd2,1'b0,2'd2,8'h00,1'b1, 1'b1,1'b1,8'h77,1'b0, 8'h3C,8'hA5,4'd3},  // R3
    '{4'd3,1'b1,2'd0,8'h11,1'b1, 1'b1,1'b0,8'h00,1'b1, 8'h3C,8'hA5,4'd4},  // R4
    '{4'd3,1'b0,2'd0,8'h22,1'b1, 1'b1,1'b0,8'h00,1'b1, 8'h3C,8'hA5,4'd4},  // R4
    '{4'd4,1'b0,2'd2,8'h00,1'b1, 1'b1,1'b0,8'h00,1'b0, 8'h77,8'hA5,4'd7},  // R7 load
    '{4'd5,1'b1,2'd3,8'h00,1'b1, 1'b1,1'b0,8'h00,1'b1, 8'h77,8'hA5,4'd7},  // R7 store
    '{4'd2,1'b1,2'd3,8'h00,1'b1, 1'b1,1'b1,8'hA5,1'b0, 8'h77,8'hA5,4'd7},  // R7
    '{4'd1,1'b1,2'd0,8'h40,1'b1, 1'b1,1'b0,8'h00,1'b0, 8'h77,8'h40,4'd2},  // R2
    '{4'd6,1'b0,2'd0,8'h00,1'b1, 1'b1,1'b0,8'h00,1'b0, 8'h22,8'h11,4'd8},  // R8 global load
    '{4'd1,1'b0,2'd0,8'hFE,1'b1, 1'b1,1'b0,8'h00,1'b0, 8'hFE,8'h11,4'd2},  // R2
    '{4'd8,1'b0,2'd0,8'h01,1'b1, 1'b1,1'b0,8'h00,1'b0, 8'hFF,8'h11,4'd9},  // R9 up
    '{4'd8,1'b0,2'd0,8'h01,1'b1, 1'b1,1'b0,8'h00,1'b0, 8'hFF,8'h11,4'd9},  // R9 top saturation
    '{4'd8,1'b1,2'd0,8'h00,1'b1, 1'b1,1'b0,8'h00,1'b0, 8'hFF,8'h10,4'd9},  // R9 down
    '{4'd1,1'b1,2'd0,8'h01,1'b1, 1'b1,1'b0,8'h00,1'b0, 8'hFF,8'h01,4'd2},  // R2
    '{4'd8,1'b1,2'd0,8'h00,1'b1, 1'b1,1'b0,8'h00,1'b0, 8'hFF,8'h00,4'd9},  // R9
    '{4'd8,1'b1,2'd0,8'h00,1'b1, 1'b1,1'b0,8'h00,1'b0, 8'hFF,8'h00,4'd9},  // R9 bottom saturation
    '{4'd7,1'b0,2'd1,8'h00,1'b1, 1'b1,1'b0,8'h00,1'b1, 8'hFF,8'h00,4'd8},  // R8 global store
    '{4'd2,1'b0,2'd1,8'h00,1'b1, 1'b1,1'b1,8'hFF,1'b0, 8'hFF,8'h00,4'd8},  // R8
    '{4'd2,1'b1,2'd1,8'h00,1'b1, 1'b1,1'b1,8'h00,1'b0, 8'hFF,8'h00,4'd8},  // R8
    '{4'd9,1'b0,2'd0,8'h5A,1'b1, 1'b0,1'b0,8'h00,1'b0, 8'hFF,8'h00,4'd11}, // R11
    '{4'd3,1'b0,2'd1,8'h55,1'b0, 1'b1,1'b0,8'h00,1'b0, 8'hFF,8'h00,4'd6},  // R6
    '{4'd2,1'b0,2'd1,8'h00,1'b0, 1'b1,1'b1,8'hFF,1'b0, 8'hFF,8'h00,4'd6},  // R6
    '{4'd7,1'b0,2'd0,8'h00,1'b0, 1'b1,1'b0,8'h00,1'b0, 8'hFF,8'h00,4'd6},  // R6
    '{4'd2,1'b0,2'd0,8'h00,1'b1, 1'b1,1'b1,8'h22,1'b0, 8'hFF,8'h00,4'd6},  // R6
    '{4'd4,1'b1,2'd3,8'h00,1'b1, 1'b1,1'b0,8'h00,1'b0, 8'hFF,8'hA5,4'd7}   // R7
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [3:0] op, input logic pot, input logic [1:0] sel,
                        input logic [7:0] data, input logic wp);
    @(negedge clk);
    cmd_op = op; cmd_pot = pot; cmd_sel = sel; cmd_data = data; wp_n = wp; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; wp_n = 1'b1;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    string r;
    int n;
    rst_n = 1'b0; wp_n = 1'b1; cmd_valid = 1'b0;
    cmd_op = '0; cmd_pot = 1'b0; cmd_sel = '0; cmd_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_idle();

    do_cmd(4'd1, 1'b0, 2'd0, 8'h3C, 1'b1);
    do_cmd(4'd1, 1'b1, 2'd0, 8'hA5, 1'b1);

    for (int i = 0; i < NV; i++) begin
      r = $sformatf("R%0d row%0d", VECS[i].req, i);
      do_cmd(VECS[i].op, VECS[i].pot, VECS[i].sel, VECS[i].data, VECS[i].wp);
      check({r, " R12"}, "accept", 32'(cmd_accept), 32'(VECS[i].acc));
      check({r, " R12"}, "reject", 32'(cmd_reject), 32'(!VECS[i].acc));
      check(r, "rd_valid", 32'(rd_valid), 32'(VECS[i].rdv));
      if (VECS[i].rdv) check(r, "rd_data", 32'(rd_data), 32'(VECS[i].rd));
      check(r, "busy", 32'(busy), 32'(VECS[i].bsy));
      check(r, "wiper0", 32'(wiper0), 32'(VECS[i].w0));
      check(r, "wiper1", 32'(wiper1), 32'(VECS[i].w1));
      check({r, " R10"}, "tap0", 32'(tap0 == (256'd1 << VECS[i].w0)), 32'd1);
      check({r, " R10"}, "tap1", 32'(tap1 == (256'd1 << VECS[i].w1)), 32'd1);
      wait_idle();
    end

    // R5: commands refused during a busy window
    do_cmd(4'd3, 1'b0, 2'd3, 8'h99, 1'b1);
    check("R4", "busy after preset write", 32'(busy), 32'd1);
    do_cmd(4'd1, 1'b0, 2'd0, 8'h10, 1'b1);
    check("R5", "reject wiper write", 32'(cmd_reject), 32'd1);
    check("R5", "wiper0 kept", 32'(wiper0), 32'hFF);
    do_cmd(4'd2, 1'b0, 2'd3, 8'h00, 1'b1);
    check("R5", "reject preset read", 32'(cmd_reject), 32'd1);
    check("R5", "no rd_valid", 32'(rd_valid), 32'd0);
    wait_idle();
    do_cmd(4'd2, 1'b0, 2'd3, 8'h00, 1'b1);
    check("R4", "preset written", 32'(rd_data), 32'h99);

    // R4: exact busy length
    do_cmd(4'd3, 1'b1, 2'd2, 8'h66, 1'b1);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    check("R4", "busy cycles", 32'(n), 32'(BUSY));
    do_cmd(4'd2, 1'b1, 2'd2, 8'h00, 1'b1);
    check("R4", "preset1 slot2", 32'(rd_data), 32'h66);

    // R1: reset and recall from preset 0
    do_cmd(4'd3, 1'b0, 2'd0, 8'h5A, 1'b1); wait_idle();
    do_cmd(4'd3, 1'b1, 2'd0, 8'hC3, 1'b1); wait_idle();
    do_cmd(4'd1, 1'b0, 2'd0, 8'h01, 1'b1);
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b1; cmd_op = 4'd1; cmd_data = 8'h44;
    #1;
    check("R1", "accept in reset", 32'(cmd_accept), 32'd0);
    check("R1", "reject in reset", 32'(cmd_reject), 32'd0);
    check("R1", "rd_valid in reset", 32'(rd_valid), 32'd0);
    check("R1", "busy in reset", 32'(busy), 32'd1);
    check("R1", "wiper0 in reset", 32'(wiper0), 32'd0);
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0; rst_n = 1'b1;
    #1;
    check("R1", "busy during recall", 32'(busy), 32'd1);
    @(negedge clk);
    check("R1", "busy after recall", 32'(busy), 32'd0);
    check("R1", "wiper0 recalled", 32'(wiper0), 32'h5A);
    check("R1", "wiper1 recalled", 32'(wiper1), 32'hC3);
    check("R10", "tap0 after recall", 32'(tap0 == (256'd1 << 8'h5A)), 32'd1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule